// File: doc/BRIEF.md
# Frequency Lock Detector and Acquisition Controller

This block decides which phase detector steers a clock-recovery loop. In acquisition the phase-frequency comparator pulls the oscillator towards the reference. In data recovery the bang-bang detector tracks the incoming data. The block divides the oscillator clock by four and counts the divided edges over a fixed window of reference cycles. It compares that count with the nominal window length and acts on the result.

A two-bit lock-select input picks one of four modes. Two modes force one detector into the loop. The other two choose the detector automatically, with a loose (2000 ppm) or a tight (500 ppm) tolerance. Monitoring never stops, so a loop that drifts away while recovering data is moved back to acquisition at the end of the next window. The lock status output is high whenever the bang-bang detector is selected. In an automatic mode it therefore alternates along with the detector choice while acquisition is going on.

The oscillator count crosses into the reference domain through a toggle request/acknowledge handshake. The snapshot is held steady until the acknowledge has been synchronized. All pins are plain control and status signals. No streaming interface is involved, so there is no back-pressure.

Top module: `freq_lock_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `det_bb_o` and `lock_o` are both 0 (acquisition).
- R2: With `lock_sel` = 2'b00 the comparator is forced into the loop: `det_bb_o` = 0 one reference cycle later, whatever the frequency error.
- R3: With `lock_sel` = 2'b01 the bang-bang detector is forced into the loop: `det_bb_o` = 1 one reference cycle later, whatever the frequency error.
- R4: With `lock_sel` = 2'b11 (tight automatic mode) the bang-bang detector is selected when |count − 2^WIN_LOG2| ≤ floor(2^WIN_LOG2·500/10^6). Otherwise the comparator is selected.
- R5: With `lock_sel` = 2'b10 (loose automatic mode) the same rule applies with a limit of floor(2^WIN_LOG2·2000/10^6).
- R6: The oscillator clock is divided by four before counting. An oscillator at exactly four times the reference frequency gives a zero error.
- R7: In an automatic mode the choice changes only when a window result arrives, once per 2^WIN_LOG2 reference cycles. Monitoring continues in data recovery, so a later frequency excursion returns the loop to acquisition.
- R8: `lock_o` is high exactly when the bang-bang detector is selected.
- R9: Any change of `lock_sel` into an automatic mode selects the comparator on the next cycle, until a later window result arrives.
- R10: The first snapshot after reset only serves as a starting point. No automatic lock is declared before two windows have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| clk_osc | input | 1 | Oscillator clock (undivided) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lock_sel | input | 2 | Mode: 00 force comparator, 01 force bang-bang, 10 auto 2000 ppm, 11 auto 500 ppm |
| det_bb_o | output | 1 | 1 = bang-bang detector in loop, 0 = comparator in loop |
| lock_o | output | 1 | Lock status |

## Verification
The bench sets the oscillator to nominal, ±1500 ppm and ±5000 ppm. These values lie between and beyond the two tolerances, so a design that swapped the limits or divided by the wrong ratio would choose the wrong detector in at least one mode. It checks that a drift occurring after lock throws the loop back to acquisition, which a design that froze monitoring once locked would miss. It checks that a mode change drops lock at once. It checks that half-way through the second window after reset there is still no lock, which catches a design that trusts its first snapshot.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam logic [1:0] LS_FORCE_CMP = 2'b00;
  localparam logic [1:0] LS_FORCE_BB  = 2'b01;
  localparam logic [1:0] LS_AUTO_WIDE = 2'b10;
  localparam logic [1:0] LS_AUTO_TIGHT = 2'b11;

  function automatic int unsigned ppm_limit(input int unsigned win_log2, input int unsigned ppm);
    longint unsigned prod;
    prod = (longint'(1) << win_log2) * longint'(ppm);
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/flk_osc_side.sv
module flk_osc_side #(
  parameter int CW = 15
) (
  input  logic          clk_osc,
  input  logic          rst_n,
  input  logic          req_tgl_i,
  output logic [CW-1:0] snap_o,
  output logic          ack_tgl_o
);
  logic [1:0]    div_q;
  logic [CW-1:0] edge_cnt;
  logic          req_s1, req_s2, req_d;
  logic          req_edge;

  assign req_edge = req_s2 ^ req_d;

  // divide by four and count divided edges
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      edge_cnt <= '0;
    end else begin
      div_q <= div_q + 2'd1;
      if (div_q == 2'd3) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      req_s1    <= 1'b0;
      req_s2    <= 1'b0;
      req_d     <= 1'b0;
      snap_o    <= '0;
      ack_tgl_o <= 1'b0;
    end else begin
      req_s1 <= req_tgl_i;
      req_s2 <= req_s1;
      req_d  <= req_s2;
      if (req_edge) begin
        snap_o    <= edge_cnt;
        ack_tgl_o <= ~ack_tgl_o;
      end
    end
  end
endmodule

// File: rtl/flk_meas_ref.sv
module flk_meas_ref #(
  parameter int WIN_LOG2 = 14,
  parameter int CW       = WIN_LOG2 + 3
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic [CW-1:0] snap_i,
  input  logic          ack_tgl_i,
  output logic          req_tgl_o,
  output logic          upd_o,
  output logic          tight_ok_o,
  output logic          wide_ok_o
);
  import flk_pkg::*;
  localparam int unsigned LIM_TIGHT = ppm_limit(WIN_LOG2, 500);
  localparam int unsigned LIM_WIDE  = ppm_limit(WIN_LOG2, 2000);
  localparam logic signed [CW:0] NOMINAL = (CW+1)'(longint'(1) << WIN_LOG2);
  localparam logic signed [CW:0] TH_T = (CW+1)'(LIM_TIGHT);
  localparam logic signed [CW:0] TH_W = (CW+1)'(LIM_WIDE);

  logic [WIN_LOG2-1:0] win_cnt;
  logic                ack_s1, ack_s2, ack_d;
  logic                ack_edge;
  logic [CW-1:0]       prev_snap;
  logic                have_prev;
  logic [CW-1:0]       diff;
  logic signed [CW:0]  err, mag;

  assign ack_edge = ack_s2 ^ ack_d;
  assign diff     = snap_i - prev_snap;
  assign err      = $signed({1'b0, diff}) - NOMINAL;
  assign mag      = (err < 0) ? -err : err;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      req_tgl_o <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (&win_cnt) req_tgl_o <= ~req_tgl_o;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1     <= 1'b0;
      ack_s2     <= 1'b0;
      ack_d      <= 1'b0;
      prev_snap  <= '0;
      have_prev  <= 1'b0;
      upd_o      <= 1'b0;
      tight_ok_o <= 1'b0;
      wide_ok_o  <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl_i;
      ack_s2 <= ack_s1;
      ack_d  <= ack_s2;
      upd_o  <= 1'b0;
      if (ack_edge) begin
        prev_snap <= snap_i;
        have_prev <= 1'b1;
        if (have_prev) begin
          upd_o      <= 1'b1;
          tight_ok_o <= (mag <= TH_T);
          wide_ok_o  <= (mag <= TH_W);
        end
      end
    end
  end

  // previous count exchange must be closed before a new window ends
  AST_HANDSHAKE_CLOSED: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (&win_cnt) |-> (req_tgl_o == ack_d)); // R7
endmodule

// File: rtl/flk_decide.sv
module flk_decide (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [1:0] lock_sel,
  input  logic       upd_i,
  input  logic       tight_ok_i,
  input  logic       wide_ok_i,
  output logic       det_bb_o
);
  import flk_pkg::*;
  logic [1:0] sel_prev;
  logic       auto_q, auto_next;
  logic       is_auto, mode_chg;

  assign is_auto  = lock_sel[1];
  assign mode_chg = (lock_sel != sel_prev);

  always_comb begin
    auto_next = auto_q;
    if (mode_chg)
      auto_next = 1'b0;
    else if (upd_i && is_auto)
      auto_next = (lock_sel == LS_AUTO_TIGHT) ? tight_ok_i : wide_ok_i;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= LS_AUTO_TIGHT;
      auto_q   <= 1'b0;
      det_bb_o <= 1'b0;
    end else begin
      sel_prev <= lock_sel;
      auto_q   <= auto_next;
      det_bb_o <= is_auto ? auto_next : lock_sel[0];
    end
  end

  AST_FORCED_CMP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (lock_sel == LS_FORCE_CMP) |=> !det_bb_o); // R2
  AST_FORCED_BB: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (lock_sel == LS_FORCE_BB) |=> det_bb_o); // R3
  AST_MODE_CHANGE_ACQ: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_chg && is_auto) |=> !det_bb_o); // R9
  AST_HOLD_IN_WINDOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (is_auto && !mode_chg && !upd_i) |=> $stable(det_bb_o)); // R7
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl #(
  parameter int WIN_LOG2 = 14
) (
  input  logic       clk_ref,
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic [1:0] lock_sel,
  output logic       det_bb_o,
  output logic       lock_o
);
  localparam int CW = WIN_LOG2 + 3;

  logic [CW-1:0] snap;
  logic          req_tgl, ack_tgl;
  logic          upd, tight_ok, wide_ok;

  flk_osc_side #(.CW(CW)) u_osc (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .req_tgl_i(req_tgl),
    .snap_o   (snap),
    .ack_tgl_o(ack_tgl)
  );

  flk_meas_ref #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_meas (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .snap_i    (snap),
    .ack_tgl_i (ack_tgl),
    .req_tgl_o (req_tgl),
    .upd_o     (upd),
    .tight_ok_o(tight_ok),
    .wide_ok_o (wide_ok)
  );

  flk_decide u_dec (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .lock_sel  (lock_sel),
    .upd_i     (upd),
    .tight_ok_i(tight_ok),
    .wide_ok_i (wide_ok),
    .det_bb_o  (det_bb_o)
  );

  assign lock_o = det_bb_o; // R8
endmodule

// File: tb/freq_lock_ctrl_test.sv
`timescale 1ps/1ps
module freq_lock_ctrl_test;
  localparam int REF_PERIOD = 80000;
  localparam int WL = 12;
  localparam int WIN = 1 << WL;

  logic       clk_ref = 1'b0;
  logic       clk_osc = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lock_sel = 2'b11;
  logic       det_bb_o, lock_o;
  int         osc_half = 10000;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  freq_lock_ctrl #(.WIN_LOG2(WL)) uut (
    .clk_ref(clk_ref), .clk_osc(clk_osc), .rst_n(rst_n),
    .lock_sel(lock_sel), .det_bb_o(det_bb_o), .lock_o(lock_o)
  );

  always #(REF_PERIOD/2) clk_ref = ~clk_ref;
  initial forever #(osc_half) clk_osc = ~clk_osc;

  function automatic int half_for(input int ppm);
    case (ppm)
      1500:    return 9985;
      -1500:   return 10015;
      5000:    return 9950;
      -5000:   return 10050;
      default: return 10000;
    endcase
  endfunction

  // expected detector after settling, from the requirements
  function automatic bit exp_bb(input logic [1:0] m, input int ppm);
    int a;
    a = (ppm < 0) ? -ppm : ppm;
    case (m)
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return a < 2000;
      default: return a < 500;
    endcase
  endfunction

  task automatic chk(input bit exp, input string req);
    checks++;
    if (det_bb_o !== exp || lock_o !== exp) begin
      fails++;
      $display("FAIL %s det_bb=%0b lock=%0b expected=%0b", req, det_bb_o, lock_o, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge clk_ref);
    @(negedge clk_ref);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_ref);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int ppms[5] = '{0, 1500, -1500, 5000, -5000};
    void'($urandom(32'd4711));
    wait_ref(10);
    chk(1'b0, "R1 reset");
    rst_n = 1'b1;
    wait_ref(2);
    chk(1'b0, "R1 after reset");
    wait_ref(WIN + WIN/2);
    chk(1'b0, "R10 no lock from first snapshot");
    wait_ref(WIN * 2);
    chk(1'b1, "R4 R6 R8 nominal lock tight");
    osc_half = half_for(1500);
    wait_ref(WIN * 3);
    chk(1'b0, "R7 R4 drift leaves lock");
    lock_sel = 2'b10;
    wait_ref(3);
    chk(1'b0, "R9 mode change drops lock");
    wait_ref(WIN * 3);
    chk(1'b1, "R5 1500ppm within wide");
    osc_half = half_for(-5000);
    wait_ref(WIN * 3);
    chk(1'b0, "R5 5000ppm outside wide");
    lock_sel = 2'b00;
    osc_half = half_for(0);
    wait_ref(3);
    chk(1'b0, "R2 forced comparator");
    lock_sel = 2'b01;
    osc_half = half_for(5000);
    wait_ref(3);
    chk(1'b1, "R3 forced bang-bang");
    for (int i = 0; i < 6; i++) begin
      logic [1:0] m;
      int p;
      m = 2'($urandom % 4);
      p = ppms[$urandom % 5];
      lock_sel = m;
      osc_half = half_for(p);
      wait_ref(WIN * 3);
      case (m)
        2'b00:   chk(exp_bb(m, p), "R2 random");
        2'b01:   chk(exp_bb(m, p), "R3 random");
        2'b10:   chk(exp_bb(m, p), "R5 random");
        default: chk(exp_bb(m, p), "R4 random");
      endcase
    end
    finish_run();
  end
endmodule